// File: doc/BRIEF.md
# Sync-Word Aligned Multi-Lane Pixel Receiver

This block takes one, two or three serial lanes, each delivering one bit per clock (the bit clock toggles on both edges at the pins, so no clock multiplication is needed), and rebuilds 30-bit pixel words from them. The stream carries no word-boundary marker in its clocking. The sending side places a fixed, unique alignment pattern in the stream during video blanking. The receiver finds the word boundary by spotting that pattern and aligns every following bit to it.

While unlocked, the block compares a sliding 30-bit window against the alignment pattern on every clock. This covers every possible bit offset within one word time. The first match locks the receiver at once, with no training. Once locked, it cuts the stream into words at the fixed period and drops alignment words silently. It presents each other word as parallel colour, sync, enable and spare bits with a one-cycle valid strobe and a parity-error flag. Lock is abandoned when the pattern fails to appear where blanking starts, or after a run of bad-parity words. The search then resumes.

Top module: `lane_sync_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `locked`, `px_valid` and `parity_err` are 0.
- R2: While unlocked, `px_valid` stays 0 whatever bits arrive.
- R3: The alignment pattern is 30'h1BC35A96. Its enable bit is 0 and its parity is even. `locked` rises on the second rising clock edge after the edge that samples the pattern's last bit, whatever the bit offset of the pattern in the stream.
- R4: Word bit b travels on lane b mod LANES in time slot b / LANES, and slot 0 is sent first. Each word takes 30/LANES clocks.
- R5: Word fields: bits 23:0 colour (`px_rgb`), bit 24 `px_hs`, bit 25 `px_vs`, bit 26 `px_de`, bits 28:27 `px_gp`, bit 29 parity.
- R6: While locked, each non-alignment word yields exactly one `px_valid` pulse. The pulse comes on the second rising edge after the edge that samples the word's last bit, and the fields hold for that cycle.
- R7: An alignment word received while locked produces no `px_valid` and keeps the lock.
- R8: A delivered word whose 30 bits have odd parity raises `parity_err` together with its `px_valid`. A word with even parity does not.
- R9: When three delivered words in a row fail parity, the third word is still output, and `locked` falls in the same cycle. Runs broken by a good word keep the lock.
- R10: If a word with bit 26 set is followed by a word with bit 26 clear that is not the alignment pattern, that word is not output and `locked` falls in the cycle it would have been output.
- R11: After losing lock, the next alignment pattern at any offset locks the receiver again, with the timing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one sample per lane per edge |
| rst | input | 1 | Synchronous active-high reset |
| lane_in | input | LANES | One serial bit per lane |
| locked | output | 1 | Word alignment established |
| px_valid | output | 1 | One-cycle strobe per delivered word |
| px_rgb | output | 24 | Colour payload |
| px_hs | output | 1 | Horizontal sync |
| px_vs | output | 1 | Vertical sync |
| px_de | output | 1 | Data enable |
| px_gp | output | 2 | Spare general-purpose bits |
| parity_err | output | 1 | Word failed even parity |

## Verification
The hardest state to reach from the ports is the lock drop on a third consecutive parity error. It has to be told apart from runs that a good word interrupts. The stimulus streams words with a flipped parity bit in a bad, good, bad, bad, good pattern, and then three bad words. This shows the count resets and then trips. The pattern is also placed at odd bit offsets behind filler bits, both at first lock and at relock. The lock-rise cycle is measured against the cycle in which the pattern's last bit was sampled.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;
  localparam int WORD_W = 30;
  localparam int DE_BIT = 26;

  typedef struct packed {
    logic [1:0]  gp;
    logic        de;
    logic        vs;
    logic        hs;
    logic [23:0] rgb;
  } pixel_t;
endpackage

// File: rtl/lsr_lane_shift.sv
`timescale 1ns/1ps
module lsr_lane_shift #(
  parameter int DEPTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic [DEPTH-1:0] hist
);
  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= bit_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[DEPTH-2:0], bit_in};
      end
    end
  endgenerate
endmodule

// File: rtl/lsr_word_assemble.sv
`timescale 1ns/1ps
module lsr_word_assemble #(
  parameter int LANES = 3,
  parameter int SLOTS = 10
) (
  input  logic [LANES-1:0][SLOTS-1:0] hist,
  output logic [LANES*SLOTS-1:0]      word
);
  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    for (genvar gs = 0; gs < SLOTS; gs++) begin : g_slot
      // oldest sample of a lane sits at the top of its history
      assign word[gs*LANES + gl] = hist[gl][SLOTS-1-gs];
    end
  end
endmodule

// File: rtl/lsr_align_ctrl.sv
`timescale 1ns/1ps
module lsr_align_ctrl
  import lsr_pkg::*;
#(
  parameter int                SLOTS      = 10,
  parameter logic [WORD_W-1:0] SYNC_WORD  = 30'h1BC35A96,
  parameter int                PERR_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  output logic              sync_hit,
  output logic              locked,
  output logic              px_valid,
  output pixel_t            px_data,
  output logic              parity_err
);
  localparam int CW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int RW = $clog2(PERR_LIMIT + 1);
  localparam logic [CW-1:0] LOCK_CNT = CW'(1 % SLOTS);

  logic [CW-1:0] cnt_q;
  logic [RW-1:0] run_q;
  logic          prev_de_q;
  logic          par_bad;
  logic          sync_missing;

  assign sync_hit     = (word == SYNC_WORD);
  assign par_bad      = ^word;
  assign sync_missing = prev_de_q && !word[DE_BIT] && !sync_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked     <= 1'b0;
      cnt_q      <= '0;
      run_q      <= '0;
      prev_de_q  <= 1'b0;
      px_valid   <= 1'b0;
      parity_err <= 1'b0;
      px_data    <= '0;
    end else begin
      px_valid   <= 1'b0;
      parity_err <= 1'b0;
      if (!locked) begin
        if (sync_hit) begin
          locked    <= 1'b1;
          cnt_q     <= LOCK_CNT;
          run_q     <= '0;
          prev_de_q <= 1'b0;
        end
      end else begin
        cnt_q <= (cnt_q == CW'(SLOTS-1)) ? '0 : cnt_q + 1'b1;
        if (cnt_q == '0) begin
          if (sync_hit) begin
            prev_de_q <= 1'b0;
          end else if (sync_missing) begin
            locked <= 1'b0;
          end else begin
            px_valid   <= 1'b1;
            parity_err <= par_bad;
            px_data    <= word[WORD_W-2:0];
            prev_de_q  <= word[DE_BIT];
            if (!par_bad) begin
              run_q <= '0;
            end else if (run_q == RW'(PERR_LIMIT-1)) begin
              run_q  <= '0;
              locked <= 1'b0;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/lane_sync_rx.sv
`timescale 1ns/1ps
module lane_sync_rx
  import lsr_pkg::*;
#(
  parameter int                LANES      = 3,
  parameter logic [WORD_W-1:0] SYNC_WORD  = 30'h1BC35A96,
  parameter int                PERR_LIMIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_in,
  output logic             locked,
  output logic             px_valid,
  output logic [23:0]      px_rgb,
  output logic             px_hs,
  output logic             px_vs,
  output logic             px_de,
  output logic [1:0]       px_gp,
  output logic             parity_err
);
  localparam int SLOTS = WORD_W / LANES;

  logic [LANES-1:0][SLOTS-1:0] hist;
  logic [WORD_W-1:0]           word;
  logic                        sync_hit;
  pixel_t                      px_data;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lsr_lane_shift #(.DEPTH(SLOTS)) shift_i (
      .clk    (clk),
      .rst    (rst),
      .bit_in (lane_in[g]),
      .hist   (hist[g])
    );
  end

  lsr_word_assemble #(.LANES(LANES), .SLOTS(SLOTS)) asm_i (
    .hist (hist),
    .word (word)
  );

  lsr_align_ctrl #(
    .SLOTS      (SLOTS),
    .SYNC_WORD  (SYNC_WORD),
    .PERR_LIMIT (PERR_LIMIT)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .word       (word),
    .sync_hit   (sync_hit),
    .locked     (locked),
    .px_valid   (px_valid),
    .px_data    (px_data),
    .parity_err (parity_err)
  );

  assign px_rgb = px_data.rgb;
  assign px_hs  = px_data.hs;
  assign px_vs  = px_data.vs;
  assign px_de  = px_data.de;
  assign px_gp  = px_data.gp;
endmodule

// File: rtl/lsr_checker.sv
`timescale 1ns/1ps
module lsr_checker #(
  parameter int PERR_LIMIT = 3
) (
  input logic clk,
  input logic rst,
  input logic locked,
  input logic px_valid,
  input logic parity_err,
  input logic sync_hit
);
  localparam int RW = $clog2(PERR_LIMIT + 1);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)                      run_q <= '0;
    else if (px_valid)            run_q <= parity_err ? run_q + 1'b1 : '0;
    else if (!locked)             run_q <= '0;
  end

  p_no_valid_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
    px_valid |-> $past(locked));

  p_lock_on_sync_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(sync_hit));

  p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    px_valid |=> !px_valid);

  p_perr_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    parity_err |-> px_valid);

  p_drop_on_run_r9: assert property (@(posedge clk) disable iff (rst)
    (px_valid && parity_err && run_q == RW'(PERR_LIMIT-1)) |-> !locked);
endmodule

bind lane_sync_rx lsr_checker #(.PERR_LIMIT(PERR_LIMIT)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .locked     (locked),
  .px_valid   (px_valid),
  .parity_err (parity_err),
  .sync_hit   (sync_hit)
);

// File: tb/lane_sync_rx_tb_top.sv
`timescale 1ns/1ps
module lane_sync_rx_tb_top;
  localparam int L     = 3;
  localparam int K     = 30 / L;
  localparam logic [29:0] SYNC = 30'h1BC35A96;
  localparam int WD_CYC = 200000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [L-1:0] lane_in = '0;
  logic         locked, px_valid, px_hs, px_vs, px_de, parity_err;
  logic [23:0]  px_rgb;
  logic [1:0]   px_gp;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_end = 0;

  typedef struct {
    logic [28:0] data;
    logic        perr;
    int          at;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  bit    rise_armed = 0, fall_armed = 0;
  int    rise_at = 0, fall_at = 0;
  string rise_tag = "R3", fall_tag = "R9";
  logic  prev_locked = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lane_sync_rx #(.LANES(L), .SYNC_WORD(SYNC), .PERR_LIMIT(3)) dut_i (
    .clk(clk), .rst(rst), .lane_in(lane_in), .locked(locked),
    .px_valid(px_valid), .px_rgb(px_rgb), .px_hs(px_hs), .px_vs(px_vs),
    .px_de(px_de), .px_gp(px_gp), .parity_err(parity_err)
  );

  task automatic check(input bit ok, input string msg, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, expv);
    end
  endtask

  function automatic logic [29:0] mk(input logic [23:0] rgb, input logic hs, input logic vs,
                                     input logic de, input logic [1:0] gp, input logic flip);
    logic [28:0] body;
    body = {gp, de, vs, hs, rgb};
    return {(^body) ^ flip, body};
  endfunction

  // monitor: compares delivered words and lock edges against expectations
  always @(negedge clk) begin
    if (!rst) begin
      if (px_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R7 unexpected px_valid", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({px_gp, px_de, px_vs, px_hs, px_rgb} == e.data,
                {e.tag, " R4 R5 fields"}, {px_gp, px_de, px_vs, px_hs, px_rgb}, e.data);
          check(cyc == e.at, {e.tag, " R6 valid cycle"}, cyc, e.at);
          check(parity_err == e.perr, {e.tag, " R8 parity_err"}, parity_err, e.perr);
        end
      end else begin
        check(!parity_err, "R8 parity_err without valid", parity_err, 0);
      end
      if (locked && !prev_locked) begin
        check(rise_armed && cyc == rise_at, {rise_tag, " lock rise cycle"}, cyc, rise_at);
        rise_armed = 0;
      end
      if (!locked && prev_locked) begin
        check(fall_armed && cyc == fall_at, {fall_tag, " lock drop cycle"}, cyc, fall_at);
        fall_armed = 0;
      end
    end
    prev_locked = locked;
  end

  task automatic send_word(input logic [29:0] w, input bit expect_out, input string tag);
    for (int s = 0; s < K; s++) begin
      @(negedge clk);
      for (int l = 0; l < L; l++) lane_in[l] = w[s*L + l];
    end
    last_end = cyc + 2;
    if (expect_out) begin
      exp_t e;
      e.data = w[28:0];
      e.perr = ^w;
      e.at   = last_end;
      e.tag  = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic send_filler(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lane_in = L'((i * 5 + seed) & 3);
    end
  endtask

  task automatic send_sync_expect_lock(input string tag);
    send_word(SYNC, 1'b0, tag);
    rise_at = last_end; rise_armed = 1; rise_tag = tag;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(!locked && !px_valid && !parity_err, "R1 outputs in reset",
          {locked, px_valid, parity_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!locked && !px_valid && !parity_err, "R1 outputs after reset",
          {locked, px_valid, parity_err}, 0);
  endtask

  task automatic t_no_lock;
    send_filler(37, 1);
    check(!locked, "R2 no lock on filler", locked, 0);
  endtask

  task automatic t_lock_and_data;
    send_filler(7, 2);
    send_sync_expect_lock("R3");
    send_word(mk(24'h123456, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0), 1'b1, "R6a");
    send_word(mk(24'hFEDCBA, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0), 1'b1, "R6b");
    send_word(mk(24'h000001, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0), 1'b1, "R6c");
    check(locked, "R3 locked after alignment", locked, 1);
  endtask

  task automatic t_sync_while_locked;
    send_word(SYNC, 1'b0, "R7");
    send_word(mk(24'hA5A5A5, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0), 1'b1, "R7a");
    send_word(mk(24'h800000, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0), 1'b1, "R7b");
    check(locked, "R7 lock kept across alignment word", locked, 1);
  endtask

  task automatic t_parity;
    send_word(mk(24'h111111, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1), 1'b1, "R8a");
    send_word(mk(24'h222222, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0), 1'b1, "R8b");
    send_word(mk(24'h333333, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1), 1'b1, "R9a");
    send_word(mk(24'h444444, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1), 1'b1, "R9b");
    send_word(mk(24'h555555, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0), 1'b1, "R9c");
    check(locked, "R9 broken run keeps lock", locked, 1);
    send_word(mk(24'h666666, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1), 1'b1, "R9d");
    send_word(mk(24'h777777, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1), 1'b1, "R9e");
    send_word(mk(24'h888888, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1), 1'b1, "R9f");
    fall_at = last_end; fall_armed = 1; fall_tag = "R9";
  endtask

  task automatic t_relock;
    send_filler(4, 3);
    send_sync_expect_lock("R11");
    send_word(mk(24'h0F0F0F, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0), 1'b1, "R11a");
    check(locked, "R11 relocked", locked, 1);
  endtask

  task automatic t_missing_sync;
    send_word(mk(24'h13579B, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0), 1'b1, "R10a");
    send_word(mk(24'h2468AC, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0), 1'b0, "R10");
    fall_at = last_end; fall_armed = 1; fall_tag = "R10";
    send_filler(5, 0);
    check(!locked, "R10 lock dropped", locked, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(WD_CYC * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_no_lock();
    t_lock_and_data();
    t_sync_while_locked();
    t_parity();
    t_relock();
    t_missing_sync();
    send_filler(30, 0);
    check(exp_q.size() == 0, "R6 all expected words delivered", exp_q.size(), 0);
    check(!rise_armed && !fall_armed, "R3 R9 R10 lock edges seen",
          {rise_armed, fall_armed}, 0);
    check(!locked, "R2 still unlocked after filler", locked, 0);
    finish_run();
  end
endmodule